// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Timing Generator

This block turns a digital sawtooth timebase into four gate-drive control bits for the two legs of a full bridge. The leading leg (outputs A and B) flips its polarity at the end of every timebase cycle. A and B therefore run as a complementary pair at half the timebase rate, each high for close to half of the output period. The lagging leg (outputs C and D) has the same waveform, delayed from the leading leg by a phase count. Converter power is set by changing that phase count. The width of the pulses is not modulated.

Each leg has its own dead-time generator. The dead time is a fixed minimum plus a programmed part, and a bypass bit per leg drops the programmed part. When adaptation is on, the programmed part scales with a current-sense code, from four times its value at zero current down to its plain value at the peak threshold. The phase count is sampled only when the leading leg flips. The sampled value is clamped so that the phase plus the lagging leg's dead time stays within half an output period.

Two state machines control the block. The timebase has the states `TB_HALT` (all counters cleared while enable is low) and `TB_RUN` (counting; it returns to `TB_HALT` as soon as enable drops). Each leg has the states `LEG_OFF`, `LEG_GAP` and `LEG_DRV`, with these transitions:
- `LEG_OFF` goes to `LEG_GAP` when enable rises.
- `LEG_DRV` goes to `LEG_GAP` when the leg's polarity changes.
- `LEG_GAP` goes to `LEG_DRV` when the gap count runs out. A polarity change during the gap restarts the gap.
- Any state goes to `LEG_OFF` when enable is low.

Top module: `pshift_bridge_pwm`

## Requirements
- R1: While reset is asserted, and after reset while enable is low, all four outputs are low.
- R2: The timebase counts PERIOD clocks per cycle. The leading leg's polarity flips at every cycle end, so each output falls once every 2*PERIOD clocks.
- R3: At every polarity change of a leg, both of its outputs stay low for exactly the leg's dead time D in clocks. The newly driven output is then high for PERIOD-D clocks. The two outputs of a leg are never high together.
- R4: The dead time is D = MIN_DT + P, where P is the programmed part. Bit 0 of `dt_bypass` sets P to 0 for leg A/B, and bit 1 does the same for leg C/D.
- R5: With `adapt_en`=0, P equals the dead-time word. With `adapt_en`=1, P = floor(word*(4*2^CS_W - 3*s)/2^CS_W), where s is `cs_code` saturated at the peak code 2^CS_W. At zero current P is four times its value at the peak.
- R6: The lagging leg's falling edges trail the leading leg's by the sampled phase in clocks: C trails A, and D trails B, by the same count.
- R7: The phase input is taken only at a leading-leg polarity flip. A change in mid-period has no effect until the next flip.
- R8: The sampled phase is min(phase, PERIOD - D_cd), where D_cd is the C/D dead time, or 0 if D_cd is PERIOD or more.
- R9: One clock after enable falls, all outputs are low. When enable rises again, the timebase restarts from zero with polarity 0, and B and D first rise D_ab and D_cd clocks after the first enabled edge.
- R10: The two legs take their dead times from independent words and bypass bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces all outputs low |
| phase | input | TB_W | Lag of leg C/D behind leg A/B, in clocks |
| dt_ab | input | DT_W | Programmed dead-time word for leg A/B |
| dt_cd | input | DT_W | Programmed dead-time word for leg C/D |
| dt_bypass | input | 2 | Per-leg removal of the programmed dead time (bit 0 A/B, bit 1 C/D) |
| adapt_en | input | 1 | Scale dead time with sensed current |
| cs_code | input | CS_W+1 | Current-sense code; peak threshold is 2^CS_W |
| out_a | output | 1 | Leg A/B high-side drive |
| out_b | output | 1 | Leg A/B low-side drive |
| out_c | output | 1 | Leg C/D high-side drive |
| out_d | output | 1 | Leg C/D low-side drive |

## Verification
The embedded properties check these rules on every cycle:
- The two outputs of a leg never overlap, and an output never turns on in the cycle right after its partner was on.
- The leading polarity flips only at a timebase wrap.
- The sampled phase holds between wraps and obeys the clamp at each latch.
- The outputs are low after any cycle with enable low.

The exact gap lengths, the high widths, the lag in clocks, the adaptive scaling, and the restart timing after re-enable depend on the programmed words. The directed scenarios demonstrate these by timing edges at the ports.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
    typedef enum logic [1:0] {
        LEG_OFF,
        LEG_GAP,
        LEG_DRV
    } leg_state_e;

    typedef enum logic {
        TB_HALT,
        TB_RUN
    } tb_state_e;
endpackage

// File: rtl/pshift_deadtime.sv
module pshift_deadtime #(
    parameter int DT_W   = 3,
    parameter int CS_W   = 4,
    parameter int MIN_DT = 3,
    parameter int DTOT_W = DT_W + 3
) (
    input  logic [DT_W-1:0]   dt_word,
    input  logic              bypass,
    input  logic              adapt_en,
    input  logic [CS_W:0]     cs_code,
    output logic [DTOT_W-1:0] dtot
);
    localparam int PW = DT_W + CS_W + 3;
    localparam logic [CS_W:0]   PEAK  = (CS_W+1)'(1 << CS_W);
    localparam logic [CS_W+2:0] FOURP = (CS_W+3)'(4 << CS_W);

    logic [CS_W:0]     cs_sat;
    logic [CS_W+2:0]   factor;
    logic [PW-1:0]     prod;
    logic [DTOT_W-1:0] prog;

    always_comb begin
        cs_sat = (cs_code > PEAK) ? PEAK : cs_code;
        // factor = 4*peak - 3*s, from 4*peak at zero current down to peak
        factor = FOURP - ({2'b00, cs_sat} + {1'b0, cs_sat, 1'b0});
        prod   = PW'(dt_word) * PW'(factor);
        if (bypass)
            prog = '0;
        else if (adapt_en)
            prog = DTOT_W'(prod >> CS_W);
        else
            prog = DTOT_W'(dt_word);
        dtot = prog + DTOT_W'(MIN_DT);
    end
endmodule

// File: rtl/pshift_timebase.sv
module pshift_timebase
    import pshift_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int TB_W   = $clog2(PERIOD),
    parameter int DTOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TB_W-1:0]   phase_in,
    input  logic [DTOT_W-1:0] dtot_lag,
    output logic              raw_lead,
    output logic              raw_lag
);
    localparam logic [TB_W-1:0] TB_LAST = TB_W'(PERIOD - 1);

    tb_state_e       st, st_n;
    logic [TB_W-1:0] tb, tb_n;
    logic [TB_W-1:0] ph_lat, ph_lat_n;
    logic            ph1_n, ph2_n;
    logic [TB_W-1:0] ph_clamp;
    logic [31:0]     lim32;
    logic            wrap;

    always_comb begin
        lim32    = (32'(dtot_lag) >= 32'(PERIOD)) ? 32'd0 : 32'(PERIOD) - 32'(dtot_lag);
        ph_clamp = (32'(phase_in) > lim32) ? TB_W'(lim32) : phase_in;
    end

    always_comb begin
        st_n     = en ? TB_RUN : TB_HALT;
        wrap     = (tb == TB_LAST);
        tb_n     = tb;
        ph1_n    = raw_lead;
        ph2_n    = raw_lag;
        ph_lat_n = ph_lat;
        unique case (st_n)
            TB_HALT: begin
                tb_n     = '0;
                ph1_n    = 1'b0;
                ph2_n    = 1'b0;
                ph_lat_n = '0;
            end
            TB_RUN: begin
                tb_n     = wrap ? '0 : tb + 1'b1;
                ph1_n    = wrap ? ~raw_lead : raw_lead;
                ph_lat_n = wrap ? ph_clamp : ph_lat;
                ph2_n    = (tb_n == ph_lat_n) ? ph1_n : raw_lag;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= TB_HALT;
            tb       <= '0;
            raw_lead <= 1'b0;
            raw_lag  <= 1'b0;
            ph_lat   <= '0;
        end else begin
            st       <= st_n;
            tb       <= tb_n;
            raw_lead <= ph1_n;
            raw_lag  <= ph2_n;
            ph_lat   <= ph_lat_n;
        end
    end

    assert_flip_at_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (raw_lead != $past(raw_lead))) |-> ($past(tb) == TB_LAST));

    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && ($past(tb) != TB_LAST)) |-> (ph_lat == $past(ph_lat)));

    assert_phase_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == TB_RUN) && (tb == '0) && ($past(tb) == TB_LAST))
            |-> ((ph_lat == '0) || (32'(ph_lat) + 32'($past(dtot_lag)) <= 32'(PERIOD))));
endmodule

// File: rtl/pshift_leg.sv
module pshift_leg
    import pshift_pkg::*;
#(
    parameter int DTOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              raw,
    input  logic [DTOT_W-1:0] dtot,
    output logic              drv_hi,
    output logic              drv_lo
);
    leg_state_e        st, st_n;
    logic [DTOT_W-1:0] cnt, cnt_n;
    logic              pol, pol_n;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        pol_n = pol;
        if (!en) begin
            st_n  = LEG_OFF;
            pol_n = raw;
        end else begin
            unique case (st)
                LEG_OFF: begin
                    st_n  = LEG_GAP;
                    cnt_n = dtot;
                    pol_n = raw;
                end
                LEG_GAP: begin
                    if (raw != pol) begin
                        cnt_n = dtot;
                        pol_n = raw;
                    end else if (cnt <= DTOT_W'(1)) begin
                        st_n = LEG_DRV;
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                end
                LEG_DRV: begin
                    if (raw != pol) begin
                        st_n  = LEG_GAP;
                        cnt_n = dtot;
                        pol_n = raw;
                    end
                end
                default: st_n = LEG_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= LEG_OFF;
            cnt <= '0;
            pol <= 1'b0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            pol <= pol_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_hi <= 1'b0;
            drv_lo <= 1'b0;
        end else begin
            drv_hi <= (st_n == LEG_DRV) && pol_n;
            drv_lo <= (st_n == LEG_DRV) && !pol_n;
        end
    end

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_hi && drv_lo));

    assert_gap_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drv_hi |-> !$past(drv_lo));

    assert_gap_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drv_lo |-> !$past(drv_hi));

    assert_off_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!drv_hi && !drv_lo));
endmodule

// File: rtl/pshift_bridge_pwm.sv
module pshift_bridge_pwm #(
    parameter int PERIOD = 40,
    parameter int DT_W   = 3,
    parameter int CS_W   = 4,
    parameter int MIN_DT = 3,
    localparam int TB_W   = $clog2(PERIOD),
    localparam int DTOT_W = DT_W + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [TB_W-1:0] phase,
    input  logic [DT_W-1:0] dt_ab,
    input  logic [DT_W-1:0] dt_cd,
    input  logic [1:0]      dt_bypass,
    input  logic            adapt_en,
    input  logic [CS_W:0]   cs_code,
    output logic            out_a,
    output logic            out_b,
    output logic            out_c,
    output logic            out_d
);
    localparam int NLEG = 2;

    logic [DT_W-1:0]   dt_sel [NLEG];
    logic [DTOT_W-1:0] dtot_w [NLEG];
    logic [NLEG-1:0]   raw_w, hi_w, lo_w;

    assign dt_sel[0] = dt_ab;
    assign dt_sel[1] = dt_cd;

    pshift_timebase #(
        .PERIOD (PERIOD),
        .TB_W   (TB_W),
        .DTOT_W (DTOT_W)
    ) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .phase_in (phase),
        .dtot_lag (dtot_w[1]),
        .raw_lead (raw_w[0]),
        .raw_lag  (raw_w[1])
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        pshift_deadtime #(
            .DT_W   (DT_W),
            .CS_W   (CS_W),
            .MIN_DT (MIN_DT),
            .DTOT_W (DTOT_W)
        ) u_dt (
            .dt_word  (dt_sel[g]),
            .bypass   (dt_bypass[g]),
            .adapt_en (adapt_en),
            .cs_code  (cs_code),
            .dtot     (dtot_w[g])
        );

        pshift_leg #(
            .DTOT_W (DTOT_W)
        ) u_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .raw    (raw_w[g]),
            .dtot   (dtot_w[g]),
            .drv_hi (hi_w[g]),
            .drv_lo (lo_w[g])
        );
    end

    assign out_a = hi_w[0];
    assign out_b = lo_w[0];
    assign out_c = hi_w[1];
    assign out_d = lo_w[1];
endmodule

// File: tb/pshift_bridge_pwm_tb.sv
`timescale 1ns/1ps
module pshift_bridge_pwm_tb;
    localparam int PERIOD = 40;
    localparam int DT_W   = 3;
    localparam int CS_W   = 4;
    localparam int MIN_DT = 3;
    localparam int TB_W   = $clog2(PERIOD);
    localparam int WIN    = PERIOD + 34;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic [TB_W-1:0] phase = '0;
    logic [DT_W-1:0] dt_ab = '0;
    logic [DT_W-1:0] dt_cd = '0;
    logic [1:0]      dt_bypass = '0;
    logic            adapt_en = 1'b0;
    logic [CS_W:0]   cs_code = '0;
    logic            out_a, out_b, out_c, out_d;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ovl = 0;
    int rise_t [4];
    int fall_t [4];
    int fall_n [4];
    logic [3:0] prev = '0;
    bit done = 1'b0;

    pshift_bridge_pwm #(
        .PERIOD (PERIOD), .DT_W (DT_W), .CS_W (CS_W), .MIN_DT (MIN_DT)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .en (en), .phase (phase),
        .dt_ab (dt_ab), .dt_cd (dt_cd), .dt_bypass (dt_bypass),
        .adapt_en (adapt_en), .cs_code (cs_code),
        .out_a (out_a), .out_b (out_b), .out_c (out_c), .out_d (out_d)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        logic [3:0] cur;
        cur = {out_d, out_c, out_b, out_a};
        for (int i = 0; i < 4; i++) begin
            if (!prev[i] && cur[i]) rise_t[i] = cyc;
            if (prev[i] && !cur[i]) begin
                fall_t[i] = cyc;
                fall_n[i]++;
            end
        end
        if ((cur[0] && cur[1]) || (cur[2] && cur[3])) ovl++;
        prev = cur;
    end

    function automatic int exp_dt(int word, bit byp, bit adapt, int cs);
        int s, p;
        s = (cs > 16) ? 16 : cs;
        if (byp) p = 0;
        else if (adapt) p = (word * (64 - 3 * s)) / 16;
        else p = word;
        return MIN_DT + p;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic sync_fall(input int idx);
        int n;
        n = fall_n[idx];
        do @(posedge clk); while (fall_n[idx] == n);
    endtask

    task automatic set_cfg(input int ph, input int wab, input int wcd,
                           input int byp, input bit ad, input int cs);
        @(negedge clk);
        phase     = TB_W'(ph);
        dt_ab     = DT_W'(wab);
        dt_cd     = DT_W'(wcd);
        dt_bypass = 2'(byp);
        adapt_en  = ad;
        cs_code   = (CS_W+1)'(cs);
        waitn(4 * PERIOD);
    endtask

    task automatic t_reset;
        en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R1", "outputs in reset", int'({out_d, out_c, out_b, out_a}), 0);
        end
        en = 1'b0;
        rst_n = 1'b1;
        waitn(5);
        @(negedge clk);
        chk("R1", "outputs after reset, enable low", int'({out_d, out_c, out_b, out_a}), 0);
    endtask

    task automatic t_basic;
        int t0, dab, dcd;
        @(negedge clk);
        en = 1'b1;
        set_cfg(10, 2, 5, 0, 1'b0, 0);
        dab = exp_dt(2, 0, 0, 0);
        dcd = exp_dt(5, 0, 0, 0);
        sync_fall(0);
        t0 = fall_t[0];
        waitn(WIN);
        chk("R3", "A/B gap", rise_t[1] - fall_t[0], dab);
        chk("R3", "B high width", fall_t[1] - rise_t[1], PERIOD - dab);
        chk("R3", "B-to-A gap", rise_t[0] - fall_t[1], dab);
        chk("R6", "C fall lag behind A", fall_t[2] - fall_t[0], 10);
        sync_fall(0);
        chk("R2", "A fall spacing", fall_t[0] - t0, 2 * PERIOD);
        sync_fall(1);
        waitn(PERIOD + 2);
        chk("R6", "D fall lag behind B", fall_t[3] - fall_t[1], 10);
        sync_fall(2);
        waitn(WIN);
        chk("R10", "C/D gap own word", rise_t[3] - fall_t[2], dcd);
        chk("R4", "D high width", fall_t[3] - rise_t[3], PERIOD - dcd);
    endtask

    task automatic t_bypass;
        set_cfg(4, 6, 5, 1, 1'b0, 0);
        sync_fall(0);
        waitn(WIN);
        chk("R4", "A/B gap with bypass", rise_t[1] - fall_t[0], MIN_DT);
        sync_fall(2);
        waitn(WIN);
        chk("R10", "C/D gap unbypassed", rise_t[3] - fall_t[2], exp_dt(5, 0, 0, 0));
        set_cfg(4, 6, 5, 2, 1'b0, 0);
        sync_fall(2);
        waitn(WIN);
        chk("R4", "C/D gap with bypass", rise_t[3] - fall_t[2], MIN_DT);
    endtask

    task automatic t_adapt;
        int gz, gp;
        set_cfg(3, 4, 1, 0, 1'b1, 0);
        sync_fall(0);
        waitn(WIN);
        gz = rise_t[1] - fall_t[0];
        chk("R5", "gap at zero current", gz, exp_dt(4, 0, 1, 0));
        set_cfg(3, 4, 1, 0, 1'b1, 16);
        sync_fall(0);
        waitn(WIN);
        gp = rise_t[1] - fall_t[0];
        chk("R5", "gap at peak current", gp, exp_dt(4, 0, 1, 16));
        chk("R5", "programmed part ratio x4", gz - MIN_DT, 4 * (gp - MIN_DT));
        set_cfg(3, 4, 1, 0, 1'b1, 8);
        sync_fall(0);
        waitn(WIN);
        chk("R5", "gap at half current", rise_t[1] - fall_t[0], exp_dt(4, 0, 1, 8));
        set_cfg(3, 4, 1, 0, 1'b1, 31);
        sync_fall(0);
        waitn(WIN);
        chk("R5", "gap with saturated code", rise_t[1] - fall_t[0], exp_dt(4, 0, 1, 16));
        set_cfg(3, 4, 1, 0, 1'b0, 0);
        sync_fall(0);
        waitn(WIN);
        chk("R5", "adapt off ignores current", rise_t[1] - fall_t[0], exp_dt(4, 0, 0, 0));
    endtask

    task automatic t_clamp;
        set_cfg(35, 1, 7, 0, 1'b0, 0);
        sync_fall(0);
        waitn(WIN);
        chk("R8", "clamped lag", fall_t[2] - fall_t[0], PERIOD - exp_dt(7, 0, 0, 0));
        set_cfg(0, 1, 7, 0, 1'b0, 0);
        sync_fall(0);
        waitn(WIN);
        chk("R6", "zero lag", fall_t[2] - fall_t[0], 0);
    endtask

    task automatic t_sample;
        set_cfg(6, 1, 1, 0, 1'b0, 0);
        sync_fall(0);
        @(negedge clk);
        phase = TB_W'(20);
        waitn(PERIOD);
        chk("R7", "mid-period change ignored", fall_t[2] - fall_t[0], 6);
        sync_fall(1);
        waitn(PERIOD);
        chk("R7", "new phase after flip", fall_t[3] - fall_t[1], 20);
    endtask

    task automatic t_enable;
        int c;
        set_cfg(8, 2, 5, 0, 1'b0, 0);
        waitn(17);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R9", "outputs one clock after disable", int'({out_d, out_c, out_b, out_a}), 0);
        waitn(6);
        @(negedge clk);
        c = cyc;
        en = 1'b1;
        @(negedge clk);
        chk("R9", "outputs at first enabled edge", int'({out_d, out_c, out_b, out_a}), 0);
        waitn(PERIOD + 5);
        chk("R9", "B first rise after enable", rise_t[1], c + 1 + exp_dt(2, 0, 0, 0));
        chk("R9", "D first rise after enable", rise_t[3], c + 1 + exp_dt(5, 0, 0, 0));
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            rise_t[i] = 0;
            fall_t[i] = 0;
            fall_n[i] = 0;
        end
        t_reset();
        t_basic();
        t_bypass();
        t_adapt();
        t_clamp();
        t_sample();
        t_enable();
        chk("R3", "cycles with a leg overlapped", ovl, 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=timeout expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule